// File: doc/BRIEF.md
# Dead-Band Pair Generator

This block turns one raw PWM level into two complementary drive signals that are never active together. Whenever the raw level changes, the output that was on drops at once, and the output that is about to turn on waits for a programmed number of enabled clock cycles. During that wait both outputs are off, which keeps a half-bridge from conducting straight through.

The turn-on of the high-side drive (following a low-to-high change of the raw level) and the turn-on of the low-side drive (following a high-to-low change) each have their own 4-bit delay count and their own counter. A count of zero makes that change pass straight through. A clock-enable input sets the timing base: the counters advance only on cycles where it is high. The delay count is captured at the cycle in which the change is seen. If the raw level flips back before a wait has finished, the pending turn-on is dropped and the opposite wait starts.

Both outputs are registered and give the active-high, pre-polarity view of the drives. Inverting them or overriding them is left to logic further downstream.

Top module: `dbnd_gen`

## Requirements
- R1: While `rst` is high, and after it is released until the first change of `pwm_in` is seen, `drv_hi` is 0 and `drv_lo` is 1. Before reset the raw level is taken to be low.
- R2: `drv_hi` and `drv_lo` are never both 1 in any cycle.
- R3: A clock edge that samples `pwm_in`=1 makes `drv_lo` 0 after that same edge.
- R4: A clock edge that samples `pwm_in`=0 makes `drv_hi` 0 after that same edge.
- R5: A low-to-high change of `pwm_in` is seen at edge k. With `rise_cnt`=N>0 and `pwm_in` held high, `drv_hi` becomes 1 after the edge that completes the N-th cycle with `tick`=1 following edge k. With `tick` always high, that is after edge k+N.
- R6: The same rule as R5 applies to a high-to-low change, with `fall_cnt` and `drv_lo`.
- R7: With a count of 0, the output being turned on goes to 1 after the same edge that sees the change, so there is no gap.
- R8: If `pwm_in` reverses before a wait has finished, the pending output never turns on. The opposite wait starts at the edge that sees the reversal.
- R9: Cycles with `tick`=0 do not advance a wait. A `tick` in the cycle where the change is seen does not count toward the wait.
- R10: The count is captured at the edge that sees the change. Changing `rise_cnt` or `fall_cnt` during a wait does not alter that wait.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timing enable; wait counters advance only when high |
| pwm_in | input | 1 | Raw PWM level |
| rise_cnt | input | CW | Delay in enabled cycles before `drv_hi` turns on |
| fall_cnt | input | CW | Delay in enabled cycles before `drv_lo` turns on |
| drv_hi | output | 1 | High-side drive, active high |
| drv_lo | output | 1 | Low-side drive, active high |

## Verification
The raw level is driven in several ways:
- **Long steady pulses with unequal counts.** These show whether each direction uses its own count and whether the gap is exactly N cycles, neither N-1 nor N+1.
- **Zero-count toggling.** This separates a true pass-through from a gap of one cycle.
- **A short pulse inside a long wait.** This exposes a design that still fires the abandoned turn-on or fails to start the opposite wait.
- **A sparse enable pattern, and a count rewritten during a wait.** These tell whether the counter follows the enable, and whether the count is captured only once, at the change.

// File: rtl/dbnd_pkg.sv
package dbnd_pkg;
  // Registered drive pair
  typedef struct packed {
    logic hi;
    logic lo;
  } drv_pair_t;

  // Index of each wait counter
  localparam int TMR_RISE = 0;
  localparam int TMR_FALL = 1;
  localparam int NUM_TMR  = 2;
endpackage

// File: rtl/dbnd_edge.sv
module dbnd_edge (
  input  logic clk,
  input  logic rst,
  input  logic pwm_in,
  output logic rise_ev,
  output logic fall_ev
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst) phase <= 1'b0;
    else     phase <= pwm_in;
  end

  assign rise_ev = pwm_in & ~phase;
  assign fall_ev = ~pwm_in & phase;
endmodule

// File: rtl/dbnd_timer.sv
module dbnd_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          start,
  input  logic [CW-1:0] load_val,
  output logic          zero_nx
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] NONE = '0;

  logic [CW-1:0] rem;
  logic [CW-1:0] rem_nx;

  always_comb begin
    if (start)                   rem_nx = load_val;
    else if (tick && rem != NONE) rem_nx = rem - ONE;
    else                         rem_nx = rem;
  end

  assign zero_nx = (rem_nx == NONE);

  always_ff @(posedge clk) begin
    if (rst) rem <= NONE;
    else     rem <= rem_nx;
  end
endmodule

// File: rtl/dbnd_drive.sv
module dbnd_drive
  import dbnd_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      lvl_nx,
  input  logic      rise_zero_nx,
  input  logic      fall_zero_nx,
  output drv_pair_t q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q.hi <= 1'b0;
      q.lo <= 1'b1;
    end else begin
      q.hi <= lvl_nx & rise_zero_nx;
      q.lo <= ~lvl_nx & fall_zero_nx;
    end
  end
endmodule

// File: rtl/dbnd_gen.sv
module dbnd_gen
  import dbnd_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          pwm_in,
  input  logic [CW-1:0] rise_cnt,
  input  logic [CW-1:0] fall_cnt,
  output logic          drv_hi,
  output logic          drv_lo
);
  logic          rise_ev;
  logic          fall_ev;
  logic          start_v [NUM_TMR];
  logic [CW-1:0] load_v  [NUM_TMR];
  logic          zero_v  [NUM_TMR];
  drv_pair_t     drv_q;

  dbnd_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .pwm_in  (pwm_in),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev)
  );

  assign start_v[TMR_RISE] = rise_ev;
  assign start_v[TMR_FALL] = fall_ev;
  assign load_v[TMR_RISE]  = rise_cnt;
  assign load_v[TMR_FALL]  = fall_cnt;

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    dbnd_timer #(.CW(CW)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .tick     (tick),
      .start    (start_v[g]),
      .load_val (load_v[g]),
      .zero_nx  (zero_v[g])
    );
  end

  dbnd_drive u_drive (
    .clk          (clk),
    .rst          (rst),
    .lvl_nx       (pwm_in),
    .rise_zero_nx (zero_v[TMR_RISE]),
    .fall_zero_nx (zero_v[TMR_FALL]),
    .q            (drv_q)
  );

  assign drv_hi = drv_q.hi;
  assign drv_lo = drv_q.lo;
endmodule

// File: rtl/dbnd_gen_chk.sv
module dbnd_gen_chk #(
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          pwm_in,
  input logic [CW-1:0] rise_cnt,
  input logic [CW-1:0] fall_cnt,
  input logic          drv_hi,
  input logic          drv_lo
);
  // R2
  no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
    !(drv_hi && drv_lo));

  // R3
  lo_drop_chk: assert property (@(posedge clk) disable iff (rst)
    pwm_in |=> !drv_lo);

  // R4
  hi_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !pwm_in |=> !drv_hi);

  // R7
  rise_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(pwm_in) && rise_cnt == '0) |=> drv_hi);

  // R7
  fall_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(pwm_in) && fall_cnt == '0) |=> drv_lo);

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !tick && $stable(pwm_in)) |=> ($stable(drv_hi) && $stable(drv_lo)));
endmodule

bind dbnd_gen dbnd_gen_chk #(.CW(CW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .pwm_in   (pwm_in),
  .rise_cnt (rise_cnt),
  .fall_cnt (fall_cnt),
  .drv_hi   (drv_hi),
  .drv_lo   (drv_lo)
);

// File: tb/dbnd_gen_bench.sv
module dbnd_gen_bench;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic          pwm_in = 1'b0;
  logic [CW-1:0] rise_cnt = '0;
  logic [CW-1:0] fall_cnt = '0;
  logic          drv_hi;
  logic          drv_lo;

  always #2 clk = ~clk;

  dbnd_gen #(.CW(CW)) u_dbnd_gen (
    .clk(clk), .rst(rst), .tick(tick), .pwm_in(pwm_in),
    .rise_cnt(rise_cnt), .fall_cnt(fall_cnt),
    .drv_hi(drv_hi), .drv_lo(drv_lo)
  );

  typedef struct {
    logic  hi;
    logic  lo;
    string tag;
  } exp_t;

  exp_t q[$];
  int   n_vec  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  // Model built from the requirements: level, enabled cycles since change, captured delay
  logic m_lvl   = 1'b0;
  int   m_since = 0;
  int   m_delay = 0;

  task automatic apply(input logic r, input logic p, input logic t,
                       input int rc, input int fc, input string tag);
    exp_t e;
    @(negedge clk);
    rst = r; pwm_in = p; tick = t;
    rise_cnt = CW'(rc); fall_cnt = CW'(fc);
    if (r) begin
      m_lvl = 1'b0; m_since = 0; m_delay = 0;
    end else if (p != m_lvl) begin
      m_lvl = p; m_since = 0; m_delay = p ? rc : fc;
    end else if (t && m_since < 1000) begin
      m_since++;
    end
    e.hi  = m_lvl && (m_since >= m_delay);
    e.lo  = !m_lvl && (m_since >= m_delay);
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic hold(input int n, input logic p, input logic t,
                      input int rc, input int fc, input string tag);
    for (int i = 0; i < n; i++) apply(1'b0, p, t, rc, fc, tag);
  endtask

  // Monitor: compare after each active edge
  always @(posedge clk) begin
    exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      n_vec++;
      if (drv_hi !== e.hi || drv_lo !== e.lo) begin
        n_fail++;
        $display("FAIL %s: hi/lo actual %b%b expected %b%b at %0t",
                 e.tag, drv_hi, drv_lo, e.hi, e.lo, $time);
      end
      if (drv_hi === 1'b1 && drv_lo === 1'b1) begin
        n_fail++;
        $display("FAIL R2: hi/lo actual 11 expected not 11 at %0t", $time);
      end
    end
  end

  initial begin
    // R1: reset state, then quiet low input
    for (int i = 0; i < 3; i++) apply(1'b1, 1'b0, 1'b1, 3, 2, "R1");
    hold(2, 1'b0, 1'b1, 3, 2, "R1");
    // R3 then R5: rising with count 3
    hold(1, 1'b1, 1'b1, 3, 2, "R3");
    hold(8, 1'b1, 1'b1, 3, 2, "R5");
    // R4 then R6: falling with count 2
    hold(1, 1'b0, 1'b1, 3, 2, "R4");
    hold(6, 1'b0, 1'b1, 3, 2, "R6");
    // R7: zero counts, fast toggling
    for (int i = 0; i < 6; i++) hold(1, (i % 2 == 0), 1'b1, 0, 0, "R7");
    hold(2, 1'b0, 1'b1, 0, 0, "R7");
    // R8: reversal inside a long rising wait
    hold(3, 1'b1, 1'b1, 8, 2, "R8");
    hold(5, 1'b0, 1'b1, 8, 2, "R8");
    hold(2, 1'b1, 1'b1, 8, 2, "R8");
    hold(1, 1'b0, 1'b1, 8, 2, "R8");
    hold(4, 1'b0, 1'b1, 8, 2, "R8");
    // R9: sparse enable, tick also high on the change cycle
    hold(1, 1'b1, 1'b1, 2, 1, "R9");
    for (int i = 0; i < 9; i++) hold(1, 1'b1, (i % 3 == 2), 2, 1, "R9");
    hold(1, 1'b0, 1'b0, 2, 1, "R9");
    hold(4, 1'b0, 1'b0, 2, 1, "R9");
    hold(3, 1'b0, 1'b1, 2, 1, "R9");
    // R10: count rewritten during the wait
    hold(1, 1'b1, 1'b1, 5, 4, "R10");
    hold(8, 1'b1, 1'b1, 1, 0, "R10");
    hold(1, 1'b0, 1'b1, 1, 4, "R10");
    hold(6, 1'b0, 1'b1, 1, 9, "R10");
    // R5/R6: maximum counts
    hold(18, 1'b1, 1'b1, 15, 15, "R5");
    hold(18, 1'b0, 1'b1, 15, 15, "R6");
    // R1: reset again while high
    hold(2, 1'b1, 1'b1, 0, 0, "R7");
    apply(1'b1, 1'b1, 1'b1, 0, 0, "R1");
    apply(1'b1, 1'b0, 1'b1, 0, 0, "R1");
    hold(2, 1'b0, 1'b1, 0, 0, "R1");
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    #20000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule